// File: doc/BRIEF.md
# Address-Masked APB GPIO Port

This block is an eight-pin general-purpose I/O port with an APB slave interface. Each pin can be set as an input or an output through a direction register. The output level comes from an output data register. The pad output-enable and output value are driven straight from these two registers. Pad inputs pass through a two-flop synchronizer before any read can see them.

The data register is reached through a 256-word address window. Address bits [9:2] of the access act as a per-pin mask, with bit 2+n selecting pin n. A write changes only the pins whose mask bit is set. A read returns zero in every position whose mask bit is clear. Software can therefore set, clear or sample a single pin in one bus transfer, with no read-modify-write sequence and no race against other code that touches other pins.

Top module: `maskio_apb`

## Requirements
- R1: After a synchronous reset, every direction bit and every output data bit is 0, so `pad_oe` and `pad_out` are 0 and all pins are inputs.
- R2: `pready` is always 1 and `pslverr` is always 0. Every transfer completes with zero wait states.
- R3: The direction register sits at byte offset 0x400. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. A read at 0x400 returns the stored value.
- R4: `pad_oe[n]` equals direction bit n, and `pad_out[n]` equals output data bit n.
- R5: A write at any offset below 0x400 uses address bits [9:2] as a mask, with paddr[2+n] belonging to pin n. Output data bit n takes `pwdata[n]` only when its mask bit is 1 and otherwise keeps its old value.
- R6: A read at any offset below 0x400 returns 0 in every bit whose mask bit (paddr[2+n]) is 0.
- R7: In a masked data read, a selected output pin returns its output data bit and a selected input pin returns its synchronized pad level.
- R8: A pad input change cannot be seen by a read whose setup phase begins one clock after the change. It can be seen from the third clock onward.
- R9: A masked write also updates the output data bits of pins that are configured as inputs. That value appears on `pad_out` and in reads once the pin becomes an output.
- R10: Reads at offsets that are neither the data window nor 0x400 return 0. Writes to those offsets change no register.
- R11: Writing `1<<n` at offset `4<<n` drives pin n high, and writing 0 there drives it low. No other pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] form the data mask |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, registered during the setup phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The bench builds the block with its defaults: eight pins, a 12-bit address and two synchronizer stages. With eight pins every mask bit from paddr[2] to paddr[9] can be tried, so one-hot, sparse and full masks can be mixed with mixed directions on the same port. With two stages the bench can land a read exactly one clock after a pad change and show the stale value, then read again later and show the new one. The narrow address still leaves room for unmapped offsets above and beside 0x400.

// File: rtl/maskio_pkg.sv
package maskio_pkg;
  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;
endpackage

// File: rtl/maskio_sync.sv
module maskio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/maskio_regs.sv
module maskio_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_dir,
  input  logic             wr_data,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)                      out_q[n] <= 1'b0;
      else if (wr_data && mask[n])  out_q[n] <= wdata[n];
    end
  end

  // R1: both registers clear after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && out_q == '0));

  // R5: unmasked output bits keep their value across a data write
  a_r5_masked_keep: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));

  // R3: direction register moves only on its own write
  a_r3_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q));

  // R10: with no write strobe, nothing changes
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (rst)
    (!wr_dir && !wr_data) |=> $stable(out_q));
endmodule

// File: rtl/maskio_apb.sv
module maskio_apb
  import maskio_pkg::*;
#(
  parameter int          NPINS       = 8,
  parameter int          ADDR_W      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [11:0] DIR_OFFSET  = 12'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [7:0]        pwdata,
  output logic [7:0]        prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam int MASK_LSB = 2;
  localparam int MASK_MSB = MASK_LSB + NPINS - 1;
  localparam int WIN_TOP  = MASK_MSB + 1;

  logic [NPINS-1:0] mask, dir_q, out_q, in_sync, data_rd;
  logic [7:0]       rd_val;
  region_e          rgn;
  logic             setup_rd, access_wr;

  assign mask = paddr[MASK_MSB:MASK_LSB];

  always_comb begin
    if (paddr[ADDR_W-1:WIN_TOP] == '0)
      rgn = RGN_DATA;
    else if (paddr[ADDR_W-1:2] == DIR_OFFSET[ADDR_W-1:2])
      rgn = RGN_DIR;
    else
      rgn = RGN_NONE;
  end

  assign setup_rd  = psel && !penable && !pwrite;
  assign access_wr = psel &&  penable &&  pwrite;

  maskio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  maskio_regs #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_dir  (access_wr && rgn == RGN_DIR),
    .wr_data (access_wr && rgn == RGN_DATA),
    .mask    (mask),
    .wdata   (pwdata[NPINS-1:0]),
    .dir_q   (dir_q),
    .out_q   (out_q)
  );

  assign data_rd = mask & ((dir_q & out_q) | (~dir_q & in_sync));

  always_comb begin
    rd_val = '0;
    case (rgn)
      RGN_DATA: rd_val[NPINS-1:0] = data_rd;
      RGN_DIR:  rd_val[NPINS-1:0] = dir_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (setup_rd) prdata <= rd_val;
    else               prdata <= '0;
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // R2: the slave never stalls and never flags an error
  a_r2_no_wait: assert property (@(posedge clk) disable iff (rst)
    psel |-> (pready && !pslverr));

  // R6: unmasked positions of a data read are zero
  a_r6_mask_zero: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && rgn == RGN_DATA) |=> ((prdata[NPINS-1:0] & ~$past(mask)) == '0));

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (setup_rd && rgn == RGN_NONE) |=> (prdata == 8'h00));
endmodule

// File: tb/test_maskio_apb.sv
module test_maskio_apb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pad_in = 8'h00, pad_out, pad_oe;
  logic        pready, pslverr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  maskio_apb i_maskio_apb (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic apb_write(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    chk("R2 ready/err", {6'd0, pready, pslverr}, 8'h02);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [11:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // monitor: the setup edge has loaded prdata; compare against the queue
  always @(posedge clk) begin
    #2;
    if (!rst && psel && !penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", prdata, 8'hxx);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, prdata, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R2 pready/pslverr idle", {6'd0, pready, pslverr}, 8'h02);
    apb_read(12'h400, 8'h00, "R1 dir after reset");
    apb_read(12'h3FC, 8'h00, "R1 data after reset");

    // R3 direction register
    apb_write(12'h400, 8'hA5);
    apb_read(12'h400, 8'hA5, "R3 dir readback");
    chk("R4 pad_oe", pad_oe, 8'hA5);

    // R5 masked write: mask 0x0F (addr 0x03C) writes 0xFF
    apb_write(12'h03C, 8'hFF);
    chk("R5 low nibble set", pad_out, 8'h0F);
    // mask 0x81 (addr 0x204) writes 0x00: clears bits 0 and 7 only
    apb_write(12'h204, 8'h00);
    chk("R5 partial clear", pad_out, 8'h0E);
    chk("R4 pad_out", pad_out, 8'h0E);

    // R6/R7 reads: dir=A5 (outputs 0,2,5,7), out=0E, pad_in=0x5A
    pad_in = 8'h5A;
    repeat (4) @(negedge clk);
    // full mask: out pins (A5 & 0E)=04, in pins (5A & 5A)=5A -> 5E
    apb_read(12'h3FC, 8'h5E, "R7 full mask mix");
    // mask 0x0F: 5E & 0F = 0E
    apb_read(12'h03C, 8'h0E, "R6 mask 0F");
    // mask 0x00 reads 0
    apb_read(12'h000, 8'h00, "R6 empty mask");

    // R8 synchronizer latency on input pin 1 (dir bit 1 = 0)
    pad_in = 8'h58;
    apb_read(12'h008, 8'h02, "R8 stale value one clock after change");
    repeat (3) @(negedge clk);
    apb_read(12'h008, 8'h00, "R8 new value after sync");

    // R9 write to an input pin, then switch it to output
    apb_write(12'h040, 8'h10);
    chk("R9 pad_oe still input", pad_oe, 8'hA5);
    chk("R9 pad_out holds written bit", pad_out, 8'h1E);
    apb_write(12'h400, 8'hB5);
    apb_read(12'h040, 8'h10, "R9 pin now output reads stored bit");

    // R11 single pin set / clear on pin 6
    apb_write(12'h400, 8'hFF);
    apb_write(12'h100, 8'h40);
    chk("R11 set pin 6", pad_out, 8'h5E);
    apb_write(12'h100, 8'h00);
    chk("R11 clear pin 6", pad_out, 8'h1E);
    apb_write(12'h004, 8'hFF);
    chk("R11 set pin 0 only", pad_out, 8'h1F);

    // R10 unmapped offsets
    apb_write(12'h800, 8'h00);
    apb_write(12'h404, 8'h00);
    apb_write(12'hC00, 8'h00);
    chk("R10 dir unchanged", pad_oe, 8'hFF);
    chk("R10 data unchanged", pad_out, 8'h1F);
    apb_read(12'h404, 8'h00, "R10 unmapped read 404");
    apb_read(12'h800, 8'h00, "R10 unmapped read 800");
    apb_read(12'h400, 8'hFF, "R10 dir readback intact");

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 pad_oe after reset", pad_oe, 8'h00);
    chk("R1 pad_out after reset", pad_out, 8'h00);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule